// File: doc/BRIEF.md
# DRAM Controller Configuration Register Block

This block holds the software-visible configuration and status words of a DRAM controller front end. It is reached through a simple 32-bit register port that selects one of four address windows: a common window, a control window, a PHY window and a second-rank probe window. Each of the first three windows covers 4 KiB of byte address space, and each implements a parameterized number of 32-bit words. Every access is answered one cycle after it is presented.

Writing the common control word reprograms the DRAM geometry when the word marks a single-rank device. The row, bank and column address widths are unpacked from fixed fields of that word. The widths then go to a downstream address-aliasing unit, together with a one-cycle update strobe. Writing the PHY initialization word completes bring-up at once by raising an init-done flag and an active flag. Reading the probe window stands for touching memory beyond the first rank. Such a read returns zero, and it raises a read-timeout flag when software has enabled that flag.

Top module: `dram_cfg_regs`

## Requirements
- R1: After reset, every implemented word in the common, control and PHY windows reads as zero, and the geometry outputs read row 1, bank 2, column 3, with no update strobe.
- R2: An accepted write to common word 0 with bit 0 clear sets the row width to bits[7:4]+1, the bank width to bit[2]+2 and the column width to bits[11:8]+3. On the edge that takes the write, the geometry changes and `geo_upd` is high for exactly the following cycle. All other bits of the word have no effect on the geometry.
- R3: An accepted write to common word 0 with bit 0 set (dual rank) stores the full value, which reads back unchanged. It leaves all three geometry outputs unchanged and raises no update strobe.
- R4: Any accepted write to control byte offset 0x000 (PHY initialization) stores the written value. It also sets bit 0 of control offset 0x010 (PHY status) and bit 0 of control offset 0x018 (controller status).
- R5: A read in the probe window (window code 3) returns zero. If bit 25 of control offset 0x100 (PHY configuration) is set, the read also sets bit 13 of control offset 0x010. If bit 25 is clear, the read changes nothing.
- R6: Flags set by hardware are sticky. They survive unrelated accesses and clear only when software writes that word, or on reset.
- R7: An access is accepted only if it is word sized (size code 2) and aligned to 4 bytes. Any other access sets `rsp_err` in the response cycle, returns zero and changes no state.
- R8: An access whose word index is at or above the implemented word count of its window sets `rsp_err` and returns zero. If the access is a write, it is ignored.
- R9: Every implemented word in the common, control and PHY windows stores the full 32-bit value written to it. `rsp_valid` and `rsp_rdata` appear in the cycle after the request. A write answers with zero data.
- R10: Window codes are 0 for common, 1 for control, 2 for PHY and 3 for the probe window. A write to the probe window is accepted with no error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window select: 0 common, 1 control, 2 PHY, 3 probe |
| req_addr | input | 12 | Byte offset inside the window |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and rejected accesses |
| rsp_err | output | 1 | Previous request was rejected |
| geo_row_bits | output | 5 | Programmed row address width |
| geo_bank_bits | output | 2 | Programmed bank address width |
| geo_col_bits | output | 5 | Programmed column address width |
| geo_upd | output | 1 | One-cycle strobe after a geometry change is taken |

## Verification
The assertions assume that the request inputs are stable and known whenever `req_valid` is high, and that only one request is in flight per cycle. They also assume that the window code never leaves its two-bit range. The bench drives every request at the falling edge, holds it for exactly one cycle and then drops `req_valid`. It therefore never overlaps two requests, and it never lets a hardware flag set coincide with a software write to the same word. Illegal sizes, misaligned offsets and out-of-range indices are presented on purpose, so that the rejection path is exercised against these same assumptions.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

   typedef enum logic [1:0] {
      WIN_COM   = 2'd0,
      WIN_CTL   = 2'd1,
      WIN_PHY   = 2'd2,
      WIN_PROBE = 2'd3
   } dcfg_win_e;

   localparam logic [1:0] SIZE_WORD = 2'd2;

   // word indices inside the control window
   localparam int CTL_PHYINIT_IDX = 0;    // byte 0x000
   localparam int CTL_PHYSTAT_IDX = 4;    // byte 0x010
   localparam int CTL_STATUS_IDX  = 6;    // byte 0x018
   localparam int CTL_PHYCFG_IDX  = 64;   // byte 0x100
   // word index of the geometry word inside the common window
   localparam int COM_GEOM_IDX    = 0;

   // bit positions
   localparam int BIT_DUAL_RANK   = 0;
   localparam int BIT_INIT_DONE   = 0;
   localparam int BIT_ACTIVE      = 0;
   localparam int BIT_RD_TIMEOUT  = 13;
   localparam int BIT_TIMEOUT_EN  = 25;

   // geometry fields in the common word
   localparam int ROW_LSB  = 4;
   localparam int ROW_FW   = 4;
   localparam int BANK_LSB = 2;
   localparam int BANK_FW  = 1;
   localparam int COL_LSB  = 8;
   localparam int COL_FW   = 4;

   localparam int ROW_BIAS  = 1;
   localparam int BANK_BIAS = 2;
   localparam int COL_BIAS  = 3;

endpackage

// File: rtl/dcfg_reg_bank.sv
module dcfg_reg_bank #(
   parameter int DEPTH = 4,
   parameter int DW    = 32,
   parameter int NSET  = 1,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IW-1:0]             wr_idx,
   input  logic [DW-1:0]             wr_data,
   input  logic [NSET-1:0]           set_en,
   input  logic [NSET-1:0][IW-1:0]   set_idx,
   input  logic [NSET-1:0][DW-1:0]   set_bits,
   output logic [DW-1:0]             regs_o [DEPTH]
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dcfg_reg_bank: DEPTH must be at least 2");
   end
   if (NSET < 1) begin : g_bad_nset
      $error("dcfg_reg_bank: NSET must be at least 1");
   end

   for (genvar r = 0; r < DEPTH; r++) begin : g_word
      logic [DW-1:0] hw_or;
      logic [DW-1:0] q;

      always_comb begin
         hw_or = '0;
         for (int s = 0; s < NSET; s++) begin
            if (set_en[s] && (set_idx[s] == IW'(r))) begin
               hw_or = hw_or | set_bits[s];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_idx == IW'(r))) begin
            q <= wr_data | hw_or;
         end else begin
            q <= q | hw_or;
         end
      end

      assign regs_o[r] = q;
   end

endmodule

// File: rtl/dcfg_geo_decode.sv
module dcfg_geo_decode #(
   parameter int ROW_FW    = 4,
   parameter int BANK_FW   = 1,
   parameter int COL_FW    = 4,
   parameter int ROW_W     = 5,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 5,
   parameter int ROW_BIAS  = 1,
   parameter int BANK_BIAS = 2,
   parameter int COL_BIAS  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_en,
   input  logic [ROW_FW-1:0]  row_fld,
   input  logic [BANK_FW-1:0] bank_fld,
   input  logic [COL_FW-1:0]  col_fld,
   output logic [ROW_W-1:0]   row_bits,
   output logic [BANK_W-1:0]  bank_bits,
   output logic [COL_W-1:0]   col_bits,
   output logic               upd
);

   localparam int ROW_MAX  = (1 << ROW_FW) - 1 + ROW_BIAS;
   localparam int BANK_MAX = (1 << BANK_FW) - 1 + BANK_BIAS;
   localparam int COL_MAX  = (1 << COL_FW) - 1 + COL_BIAS;

   if (ROW_MAX >= (1 << ROW_W)) begin : g_bad_row
      $error("dcfg_geo_decode: ROW_W too narrow");
   end
   if (BANK_MAX >= (1 << BANK_W)) begin : g_bad_bank
      $error("dcfg_geo_decode: BANK_W too narrow");
   end
   if (COL_MAX >= (1 << COL_W)) begin : g_bad_col
      $error("dcfg_geo_decode: COL_W too narrow");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_bits  <= ROW_W'(ROW_BIAS);
         bank_bits <= BANK_W'(BANK_BIAS);
         col_bits  <= COL_W'(COL_BIAS);
         upd       <= 1'b0;
      end else begin
         upd <= upd_en;
         if (upd_en) begin
            row_bits  <= ROW_W'(row_fld) + ROW_W'(ROW_BIAS);
            bank_bits <= BANK_W'(bank_fld) + BANK_W'(BANK_BIAS);
            col_bits  <= COL_W'(col_fld) + COL_W'(COL_BIAS);
         end
      end
   end

endmodule

// File: rtl/dcfg_req_decode.sv
module dcfg_req_decode #(
   parameter int AW        = 12,
   parameter int COM_WORDS = 4,
   parameter int CTL_WORDS = 72,
   parameter int PHY_WORDS = 32,
   localparam int IDXW     = AW - 2
) (
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [1:0]      req_win,
   input  logic [AW-1:0]   req_addr,
   input  logic [1:0]      req_size,
   output logic [IDXW-1:0] idx,
   output logic            accept,
   output logic            reject,
   output logic [3:0]      win_wr,
   output logic [3:0]      win_rd
);
   import dcfg_pkg::*;

   localparam logic [IDXW-1:0] COM_LIM = IDXW'(COM_WORDS);
   localparam logic [IDXW-1:0] CTL_LIM = IDXW'(CTL_WORDS);
   localparam logic [IDXW-1:0] PHY_LIM = IDXW'(PHY_WORDS);

   logic shape_ok;
   logic in_range;

   assign idx      = req_addr[AW-1:2];
   assign shape_ok = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);

   always_comb begin
      unique case (dcfg_win_e'(req_win))
         WIN_COM: in_range = idx < COM_LIM;
         WIN_CTL: in_range = idx < CTL_LIM;
         WIN_PHY: in_range = idx < PHY_LIM;
         default: in_range = 1'b1;
      endcase
   end

   assign accept = req_valid && shape_ok && in_range;
   assign reject = req_valid && !accept;

   for (genvar w = 0; w < 4; w++) begin : g_win
      assign win_wr[w] = accept &&  req_write && (req_win == 2'(w));
      assign win_rd[w] = accept && !req_write && (req_win == 2'(w));
   end

endmodule

// File: rtl/dram_cfg_regs.sv
module dram_cfg_regs #(
   parameter int DW        = 32,
   parameter int AW        = 12,
   parameter int COM_WORDS = 4,
   parameter int CTL_WORDS = 72,
   parameter int PHY_WORDS = 32,
   parameter int ROW_W     = 5,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_win,
   input  logic [AW-1:0]     req_addr,
   input  logic [1:0]        req_size,
   input  logic [DW-1:0]     req_wdata,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic              rsp_err,
   output logic [ROW_W-1:0]  geo_row_bits,
   output logic [BANK_W-1:0] geo_bank_bits,
   output logic [COL_W-1:0]  geo_col_bits,
   output logic              geo_upd
);
   import dcfg_pkg::*;

   localparam int IDXW   = AW - 2;
   localparam int COM_IW = $clog2(COM_WORDS);
   localparam int CTL_IW = $clog2(CTL_WORDS);
   localparam int PHY_IW = $clog2(PHY_WORDS);
   localparam int CTL_NSET = 3;

   if (DW != 32) begin : g_bad_dw
      $error("dram_cfg_regs: register port is word-only, DW must be 32");
   end
   if (AW != 12) begin : g_bad_aw
      $error("dram_cfg_regs: each window spans 4 KiB, AW must be 12");
   end
   if (COM_WORDS < 2 || COM_WORDS >= (1 << IDXW)) begin : g_bad_com
      $error("dram_cfg_regs: COM_WORDS out of range");
   end
   if (CTL_WORDS <= CTL_PHYCFG_IDX || CTL_WORDS >= (1 << IDXW)) begin : g_bad_ctl
      $error("dram_cfg_regs: CTL_WORDS must cover the PHY configuration word");
   end
   if (PHY_WORDS < 2 || PHY_WORDS >= (1 << IDXW)) begin : g_bad_phy
      $error("dram_cfg_regs: PHY_WORDS out of range");
   end

   // ---------------- request decode ----------------
   logic [IDXW-1:0] idx;
   logic            accept;
   logic            reject;
   logic [3:0]      win_wr;
   logic [3:0]      win_rd;

   dcfg_req_decode #(
      .AW        (AW),
      .COM_WORDS (COM_WORDS),
      .CTL_WORDS (CTL_WORDS),
      .PHY_WORDS (PHY_WORDS)
   ) i_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_win   (req_win),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .idx       (idx),
      .accept    (accept),
      .reject    (reject),
      .win_wr    (win_wr),
      .win_rd    (win_rd)
   );

   logic [COM_IW-1:0] com_idx;
   logic [CTL_IW-1:0] ctl_idx;
   logic [PHY_IW-1:0] phy_idx;

   assign com_idx = idx[COM_IW-1:0];
   assign ctl_idx = idx[CTL_IW-1:0];
   assign phy_idx = idx[PHY_IW-1:0];

   // ---------------- register windows ----------------
   logic [DW-1:0] com_q [COM_WORDS];
   logic [DW-1:0] ctl_q [CTL_WORDS];
   logic [DW-1:0] phy_q [PHY_WORDS];

   dcfg_reg_bank #(
      .DEPTH (COM_WORDS),
      .DW    (DW),
      .NSET  (1)
   ) i_com (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (win_wr[WIN_COM]),
      .wr_idx   (com_idx),
      .wr_data  (req_wdata),
      .set_en   (1'b0),
      .set_idx  ('0),
      .set_bits ('0),
      .regs_o   (com_q)
   );

   logic                           pir_wr;
   logic                           probe_timeout;
   logic [CTL_NSET-1:0]            ctl_set_en;
   logic [CTL_NSET-1:0][CTL_IW-1:0] ctl_set_idx;
   logic [CTL_NSET-1:0][DW-1:0]    ctl_set_bits;

   assign pir_wr        = win_wr[WIN_CTL] && (ctl_idx == CTL_IW'(CTL_PHYINIT_IDX));
   assign probe_timeout = win_rd[WIN_PROBE] && ctl_q[CTL_PHYCFG_IDX][BIT_TIMEOUT_EN];

   assign ctl_set_en[0]   = pir_wr;
   assign ctl_set_idx[0]  = CTL_IW'(CTL_PHYSTAT_IDX);
   assign ctl_set_bits[0] = DW'(1) << BIT_INIT_DONE;

   assign ctl_set_en[1]   = pir_wr;
   assign ctl_set_idx[1]  = CTL_IW'(CTL_STATUS_IDX);
   assign ctl_set_bits[1] = DW'(1) << BIT_ACTIVE;

   assign ctl_set_en[2]   = probe_timeout;
   assign ctl_set_idx[2]  = CTL_IW'(CTL_PHYSTAT_IDX);
   assign ctl_set_bits[2] = DW'(1) << BIT_RD_TIMEOUT;

   dcfg_reg_bank #(
      .DEPTH (CTL_WORDS),
      .DW    (DW),
      .NSET  (CTL_NSET)
   ) i_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (win_wr[WIN_CTL]),
      .wr_idx   (ctl_idx),
      .wr_data  (req_wdata),
      .set_en   (ctl_set_en),
      .set_idx  (ctl_set_idx),
      .set_bits (ctl_set_bits),
      .regs_o   (ctl_q)
   );

   dcfg_reg_bank #(
      .DEPTH (PHY_WORDS),
      .DW    (DW),
      .NSET  (1)
   ) i_phy (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (win_wr[WIN_PHY]),
      .wr_idx   (phy_idx),
      .wr_data  (req_wdata),
      .set_en   (1'b0),
      .set_idx  ('0),
      .set_bits ('0),
      .regs_o   (phy_q)
   );

   // ---------------- geometry ----------------
   logic geo_take;

   assign geo_take = win_wr[WIN_COM] && (com_idx == COM_IW'(COM_GEOM_IDX))
                     && !req_wdata[BIT_DUAL_RANK];

   dcfg_geo_decode #(
      .ROW_FW    (ROW_FW),
      .BANK_FW   (BANK_FW),
      .COL_FW    (COL_FW),
      .ROW_W     (ROW_W),
      .BANK_W    (BANK_W),
      .COL_W     (COL_W),
      .ROW_BIAS  (ROW_BIAS),
      .BANK_BIAS (BANK_BIAS),
      .COL_BIAS  (COL_BIAS)
   ) i_geo (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (geo_take),
      .row_fld   (req_wdata[ROW_LSB +: ROW_FW]),
      .bank_fld  (req_wdata[BANK_LSB +: BANK_FW]),
      .col_fld   (req_wdata[COL_LSB +: COL_FW]),
      .row_bits  (geo_row_bits),
      .bank_bits (geo_bank_bits),
      .col_bits  (geo_col_bits),
      .upd       (geo_upd)
   );

   // ---------------- response ----------------
   logic [DW-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (win_rd[WIN_COM]) rd_mux = com_q[com_idx];
      if (win_rd[WIN_CTL]) rd_mux = ctl_q[ctl_idx];
      if (win_rd[WIN_PHY]) rd_mux = phy_q[phy_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= reject;
         rsp_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/dram_cfg_regs_chk.sv
module dram_cfg_regs_chk #(
   parameter int DW        = 32,
   parameter int AW        = 12,
   parameter int CTL_WORDS = 72,
   parameter int ROW_W     = 5,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_win,
   input logic [AW-1:0]     req_addr,
   input logic [1:0]        req_size,
   input logic [DW-1:0]     req_wdata,
   input logic              rsp_valid,
   input logic [DW-1:0]     rsp_rdata,
   input logic              rsp_err,
   input logic [ROW_W-1:0]  geo_row_bits,
   input logic [BANK_W-1:0] geo_bank_bits,
   input logic [COL_W-1:0]  geo_col_bits,
   input logic              geo_upd,
   input logic [DW-1:0]     ctl_regs [CTL_WORDS]
);

   logic geom_wr;
   logic pir_wr_req;
   logic physt_wr_req;
   logic probe_rd;
   logic [DW-1:0] physt;
   logic [DW-1:0] stat;

   assign geom_wr      = req_valid && req_write && (req_win == 2'd0)
                         && (req_addr == '0) && (req_size == 2'd2);
   assign pir_wr_req   = req_valid && req_write && (req_win == 2'd1)
                         && (req_addr == '0) && (req_size == 2'd2);
   assign physt_wr_req = req_valid && req_write && (req_win == 2'd1)
                         && (req_addr == AW'(16)) && (req_size == 2'd2);
   assign probe_rd     = req_valid && !req_write && (req_win == 2'd3)
                         && (req_addr[1:0] == 2'b00) && (req_size == 2'd2);
   assign physt = ctl_regs[4];
   assign stat  = ctl_regs[6];

   AST_GEO_UPD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      geo_upd |-> $past(geom_wr && !req_wdata[0])); // R2

   AST_GEO_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_bank_bits >= BANK_W'(2)) && (geo_row_bits != '0) && (geo_col_bits >= COL_W'(3))); // R2

   AST_DUAL_RANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (geom_wr && req_wdata[0]) |=> (!geo_upd && $stable(geo_row_bits)
                                     && $stable(geo_bank_bits) && $stable(geo_col_bits))); // R3

   AST_PIR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      pir_wr_req |=> (physt[0] && stat[0])); // R4

   AST_PROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      probe_rd |=> (rsp_valid && (rsp_rdata == '0))); // R5

   AST_STICKY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(physt[0]) |-> $past(physt_wr_req)); // R6

   AST_SIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_size != 2'd2)) |=> (rsp_err && (rsp_rdata == '0))); // R7

   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && (rsp_rdata == '0))); // R8

   AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R9

endmodule

bind dram_cfg_regs dram_cfg_regs_chk #(
   .DW        (DW),
   .AW        (AW),
   .CTL_WORDS (CTL_WORDS),
   .ROW_W     (ROW_W),
   .BANK_W    (BANK_W),
   .COL_W     (COL_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_write     (req_write),
   .req_win       (req_win),
   .req_addr      (req_addr),
   .req_size      (req_size),
   .req_wdata     (req_wdata),
   .rsp_valid     (rsp_valid),
   .rsp_rdata     (rsp_rdata),
   .rsp_err       (rsp_err),
   .geo_row_bits  (geo_row_bits),
   .geo_bank_bits (geo_bank_bits),
   .geo_col_bits  (geo_col_bits),
   .geo_upd       (geo_upd),
   .ctl_regs      (ctl_q)
);

// File: tb/test_dram_cfg_regs.sv
module test_dram_cfg_regs;

   localparam int CLK_PERIOD = 10;
   localparam int COM_WORDS  = 4;
   localparam int CTL_WORDS  = 72;
   localparam int PHY_WORDS  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_win = 2'd0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic [4:0]  geo_row_bits;
   logic [1:0]  geo_bank_bits;
   logic [4:0]  geo_col_bits;
   logic        geo_upd;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        s_valid;
   logic [31:0] s_rdata;
   logic        s_err;
   logic        s_upd;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_cfg_regs #(
      .COM_WORDS (COM_WORDS),
      .CTL_WORDS (CTL_WORDS),
      .PHY_WORDS (PHY_WORDS)
   ) i_dram_cfg_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_win       (req_win),
      .req_addr      (req_addr),
      .req_size      (req_size),
      .req_wdata     (req_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .rsp_err       (rsp_err),
      .geo_row_bits  (geo_row_bits),
      .geo_bank_bits (geo_bank_bits),
      .geo_col_bits  (geo_col_bits),
      .geo_upd       (geo_upd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one request, sampled at the falling edge after the taking edge
   task automatic access(input logic wr, input logic [1:0] win, input logic [11:0] addr,
                         input logic [1:0] size, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_win   = win;
      req_addr  = addr;
      req_size  = size;
      req_wdata = wd;
      @(negedge clk);
      s_valid = rsp_valid;
      s_rdata = rsp_rdata;
      s_err   = rsp_err;
      s_upd   = geo_upd;
      req_valid = 1'b0;
   endtask

   task automatic rd(input logic [1:0] win, input logic [11:0] addr);
      access(1'b0, win, addr, 2'd2, 32'h0);
   endtask

   task automatic wr(input logic [1:0] win, input logic [11:0] addr, input logic [31:0] d);
      access(1'b1, win, addr, 2'd2, d);
   endtask

   task automatic check_geo(input string req, input int row, input int bank, input int col);
      check(req, {27'd0, geo_row_bits}, 32'(row));
      check(req, {30'd0, geo_bank_bits}, 32'(bank));
      check(req, {27'd0, geo_col_bits}, 32'(col));
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] pat;
      int lr, lb, lc;
      do_reset();

      // R1: reset state
      check_geo("R1 geometry after reset", 1, 2, 3);
      check("R1 no strobe after reset", {31'd0, geo_upd}, 32'd0);
      for (int i = 0; i < COM_WORDS; i++) begin
         rd(2'd0, 12'(i * 4));
         check("R1 common word zero", s_rdata, 32'd0);
      end
      for (int i = 0; i < CTL_WORDS; i++) begin
         rd(2'd1, 12'(i * 4));
         check("R1 control word zero", s_rdata, 32'd0);
      end
      for (int i = 0; i < PHY_WORDS; i++) begin
         rd(2'd2, 12'(i * 4));
         check("R1 PHY word zero", s_rdata, 32'd0);
      end

      // R2: exhaustive geometry sweep, with noise in non-field bits
      for (int r = 0; r < 16; r++) begin
         for (int c = 0; c < 16; c++) begin
            for (int b = 0; b < 2; b++) begin
               pat = 32'hA5A5_0000 | (32'(c) << 8) | (32'(r) << 4) | (32'(b) << 2)
                     | (32'((r + c) & 1) << 1) | (32'(b ^ (c & 1)) << 3);
               wr(2'd0, 12'h000, pat);
               check("R2 update strobe", {31'd0, s_upd}, 32'd1);
               check("R9 write response valid", {31'd0, s_valid}, 32'd1);
               check_geo("R2 geometry decode", r + 1, b + 2, c + 3);
               @(negedge clk);
               check("R2 strobe one cycle", {31'd0, geo_upd}, 32'd0);
            end
         end
      end
      lr = 6; lb = 1; lc = 9;
      wr(2'd0, 12'h000, (32'(lc) << 8) | (32'(lr) << 4) | (32'(lb) << 2));
      check_geo("R2 geometry reprogram", lr + 1, lb + 2, lc + 3);

      // R3: dual rank write keeps geometry
      wr(2'd0, 12'h000, 32'h0000_0FF1);
      check("R3 no strobe on dual rank", {31'd0, s_upd}, 32'd0);
      check_geo("R3 geometry held", lr + 1, lb + 2, lc + 3);
      rd(2'd0, 12'h000);
      check("R3 dual rank value stored", s_rdata, 32'h0000_0FF1);

      // R9: PHY window storage sweep
      for (int i = 0; i < PHY_WORDS; i++) begin
         wr(2'd2, 12'(i * 4), 32'h1357_0000 ^ (32'(i) * 32'h0101_0101));
         check("R9 write data zero", s_rdata, 32'd0);
      end
      for (int i = 0; i < PHY_WORDS; i++) begin
         rd(2'd2, 12'(i * 4));
         check("R9 PHY readback", s_rdata, 32'h1357_0000 ^ (32'(i) * 32'h0101_0101));
      end
      wr(2'd0, 12'h00C, 32'hDEAD_BEEF);
      rd(2'd0, 12'h00C);
      check("R9 common word 3 readback", s_rdata, 32'hDEAD_BEEF);

      // R4: PHY init
      wr(2'd1, 12'h000, 32'h0000_0173);
      rd(2'd1, 12'h000);
      check("R4 init word stored", s_rdata, 32'h0000_0173);
      rd(2'd1, 12'h010);
      check("R4 init done flag", s_rdata, 32'h0000_0001);
      rd(2'd1, 12'h018);
      check("R4 active flag", s_rdata, 32'h0000_0001);

      // R5: probe read without timeout enable
      rd(2'd3, 12'h000);
      check("R5 probe returns zero", s_rdata, 32'd0);
      check("R5 probe no error", {31'd0, s_err}, 32'd0);
      rd(2'd1, 12'h010);
      check("R5 no timeout when disabled", s_rdata, 32'h0000_0001);
      // enable, then probe
      wr(2'd1, 12'h100, 32'h0200_0000);
      rd(2'd3, 12'h040);
      check("R5 probe returns zero enabled", s_rdata, 32'd0);
      rd(2'd1, 12'h010);
      check("R5 timeout flag set", s_rdata, 32'h0000_2001);

      // R10: write to probe window accepted with no effect
      wr(2'd3, 12'h000, 32'hFFFF_FFFF);
      check("R10 probe write no error", {31'd0, s_err}, 32'd0);
      rd(2'd1, 12'h010);
      check("R10 probe write no effect", s_rdata, 32'h0000_2001);
      check_geo("R10 probe write geometry", lr + 1, lb + 2, lc + 3);

      // R6: sticky until direct write
      wr(2'd1, 12'h014, 32'h1111_1111);
      rd(2'd1, 12'h010);
      check("R6 flags survive neighbour write", s_rdata, 32'h0000_2001);
      wr(2'd1, 12'h010, 32'h0000_0000);
      rd(2'd1, 12'h010);
      check("R6 direct write clears flags", s_rdata, 32'd0);
      rd(2'd1, 12'h018);
      check("R6 active flag still set", s_rdata, 32'h0000_0001);

      // R7: size and alignment
      for (int sz = 0; sz < 4; sz++) begin
         if (sz != 2) begin
            access(1'b1, 2'd2, 12'h008, 2'(sz), 32'hCAFE_0000);
            check("R7 bad size rejected", {31'd0, s_err}, 32'd1);
            access(1'b0, 2'd2, 12'h008, 2'(sz), 32'h0);
            check("R7 bad size read zero", s_rdata, 32'd0);
         end
      end
      access(1'b1, 2'd2, 12'h00A, 2'd2, 32'hCAFE_0001);
      check("R7 misaligned rejected", {31'd0, s_err}, 32'd1);
      rd(2'd2, 12'h008);
      check("R7 word unchanged", s_rdata, 32'h1357_0000 ^ 32'h0202_0202);
      access(1'b1, 2'd0, 12'h000, 2'd1, 32'h0000_0000);
      check("R7 bad size no strobe", {31'd0, s_upd}, 32'd0);
      check_geo("R7 bad size geometry held", lr + 1, lb + 2, lc + 3);

      // R8: out-of-range
      rd(2'd1, 12'(CTL_WORDS * 4));
      check("R8 control beyond range err", {31'd0, s_err}, 32'd1);
      check("R8 control beyond range zero", s_rdata, 32'd0);
      wr(2'd2, 12'(PHY_WORDS * 4), 32'h7777_7777);
      check("R8 PHY beyond range err", {31'd0, s_err}, 32'd1);
      rd(2'd2, 12'h000);
      check("R8 PHY word 0 unchanged", s_rdata, 32'h1357_0000);
      wr(2'd0, 12'(COM_WORDS * 4), 32'h0000_0000);
      check("R8 common beyond range err", {31'd0, s_err}, 32'd1);
      check("R8 common beyond range no strobe", {31'd0, s_upd}, 32'd0);
      rd(2'd0, 12'hFFC);
      check("R8 top of window err", {31'd0, s_err}, 32'd1);
      rd(2'd1, 12'h11C);
      check("R8 last control word ok", {31'd0, s_err}, 32'd0);

      // R1: reset clears again
      do_reset();
      check_geo("R1 geometry after second reset", 1, 2, 3);
      rd(2'd1, 12'h010);
      check("R1 PHY status cleared", s_rdata, 32'd0);
      rd(2'd2, 12'h004);
      check("R1 PHY word cleared", s_rdata, 32'd0);
      rd(2'd0, 12'h000);
      check("R1 common word cleared", s_rdata, 32'd0);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule